// File: doc/BRIEF.md
# Inter-Processor Mailbox Controller

This block lets a set of processor channels pass short fixed-length messages to one another and interrupt each other. It is a memory-mapped peripheral on a simple register bus with a write strobe, a read strobe, a 12-bit byte address and 32-bit data. It has one interrupt line per channel. A parameterised number of mailboxes sit side by side. Each mailbox has an owning source channel, a set of destination channels, a per-channel interrupt enable mask, a mode word, a send state and a small payload of data words.

A sender claims a mailbox by writing its one-hot channel bit to the source register. It picks receivers and enables interrupts through set/clear register pairs, fills the payload and writes 1 to the send register. The destinations are interrupted. A receiver reads the payload and writes 2, which interrupts the source instead. Writing 0 to the send register returns the mailbox to idle. Per-channel summary words show, one bit per mailbox, which mailboxes are raising that channel's interrupt, both before and after masking. The low two address bits are ignored.

Top module: `ipc_mailbox_hub`

## Requirements
- R1: After reset every register reads zero, bus_rdata is zero and every irq_out bit is low.
- R2: Mailbox b occupies byte addresses 64·b to 64·b+63. Its data word k (k from 0 to DATA_WORDS-1) sits at offset 0x24+4·k and reads back the last value written to it.
- R3: Writing to offset 0x04 ORs the written bits into the destination set. Writing to 0x08 clears the bits written as 1. Offset 0x0C reads the current destination set.
- R4: Writing to offset 0x14 ORs the written bits into the interrupt mask. Writing to 0x18 clears the bits written as 1. Offset 0x1C reads the current mask.
- R5: The source register is at offset 0x00. A nonzero write takes effect only while the register is zero, and otherwise leaves it unchanged.
- R6: Writing zero to the source register clears source, destination set, mask, mode and send state. The data words keep their values.
- R7: The send register is at offset 0x20 and stores the low two bits written. Raw bit b for channel c is 1 when mailbox b has send=1 and c is in its destination set, or send=2 and c is its source. Send=0 raises nothing.
- R8: A masked bit is the raw bit ANDed with the mailbox's mask bit for that channel. irq_out[c] is the OR of channel c's masked bits over all mailboxes.
- R9: The masked status word of channel n reads at 0x800+8·n and the raw word at 0x804+8·n. Bit b of each word belongs to mailbox b.
- R10: Reads of mailboxes at or above NUM_BOX, of channel words at or above NUM_CHAN, and of absent data words return zero. Writes to these addresses, and any write at 0x800 or above, change nothing.
- R11: bus_rdata carries the addressed word from the clock edge that samples bus_re and holds it until the next read. irq_out follows a register write from the same clock edge.
- R12: The mode register is at offset 0x10. It stores the low MODE_W bits written and does not affect interrupts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, sampled at the rising edge |
| bus_re | input | 1 | Read strobe, sampled at the rising edge |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | NUM_CHAN | Interrupt line per channel |

## Verification
A read is due one clock after its strobe. The bench queues each expected word when the strobe is driven. A monitor pops the queue at the falling edge that follows the capturing rising edge, so every compare sees the registered value exactly once. The interrupt lines have no register of their own between the state and the pin, so they are due in the same cycle as the write that changes them. The bench checks them at the falling edge right after that write. A held read word is checked again after idle cycles to confirm it does not move.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;
   localparam int ADDR_W = 12;
   localparam int WORD_W = 32;

   // word index within a mailbox window (offset / 4)
   typedef enum logic [3:0] {
      REG_SRC   = 4'd0,
      REG_DSET  = 4'd1,
      REG_DCLR  = 4'd2,
      REG_DSTAT = 4'd3,
      REG_MODE  = 4'd4,
      REG_MSET  = 4'd5,
      REG_MCLR  = 4'd6,
      REG_MSTAT = 4'd7,
      REG_SEND  = 4'd8
   } reg_sel_e;

   localparam logic [3:0] DATA_BASE = 4'd9;

   localparam logic [1:0] SEND_IDLE = 2'd0;
   localparam logic [1:0] SEND_REQ  = 2'd1;
   localparam logic [1:0] SEND_ACK  = 2'd2;
endpackage

// File: rtl/ipc_mbx_slot.sv
module ipc_mbx_slot
   import ipc_mbx_pkg::*;
#(
   parameter int NUM_CHAN   = 8,
   parameter int DATA_WORDS = 7,
   parameter int MODE_W     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [3:0]          word_sel,
   input  logic [WORD_W-1:0]   wdata,
   output logic [WORD_W-1:0]   rd_word,
   output logic [NUM_CHAN-1:0] src_q,
   output logic [NUM_CHAN-1:0] dst_q,
   output logic [NUM_CHAN-1:0] msk_q,
   output logic [1:0]          send_q
);
   localparam int MODE_KEEP = (MODE_W > 0) ? MODE_W : 1;

   logic [DATA_WORDS-1:0][WORD_W-1:0] dat_q;
   logic [NUM_CHAN-1:0]               wchan;
   logic [WORD_W-1:0]                 mode_rd;
   logic                              release_w;

   assign wchan     = wdata[NUM_CHAN-1:0];
   assign release_w = wr_en && (word_sel == REG_SRC) && (wchan == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         msk_q  <= '0;
         send_q <= SEND_IDLE;
      end else if (release_w) begin
         src_q  <= '0;
         dst_q  <= '0;
         msk_q  <= '0;
         send_q <= SEND_IDLE;
      end else if (wr_en) begin
         case (reg_sel_e'(word_sel))
            REG_SRC:  if (src_q == '0) src_q <= wchan;
            REG_DSET: dst_q  <= dst_q | wchan;
            REG_DCLR: dst_q  <= dst_q & ~wchan;
            REG_MSET: msk_q  <= msk_q | wchan;
            REG_MCLR: msk_q  <= msk_q & ~wchan;
            REG_SEND: send_q <= wdata[1:0];
            default: ;
         endcase
      end
   end

   generate
      if (MODE_W > 0) begin : g_mode
         logic [MODE_KEEP-1:0] mode_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                mode_q <= '0;
            else if (release_w)                        mode_q <= '0;
            else if (wr_en && word_sel == REG_MODE)    mode_q <= wdata[MODE_KEEP-1:0];
         end
         assign mode_rd = WORD_W'(mode_q);
      end else begin : g_nomode
         assign mode_rd = '0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dat_q <= '0;
      end else if (wr_en) begin
         for (int k = 0; k < DATA_WORDS; k++)
            if (word_sel == DATA_BASE + 4'(k)) dat_q[k] <= wdata;
      end
   end

   always_comb begin
      rd_word = '0;
      case (reg_sel_e'(word_sel))
         REG_SRC:   rd_word = WORD_W'(src_q);
         REG_DSTAT: rd_word = WORD_W'(dst_q);
         REG_MODE:  rd_word = mode_rd;
         REG_MSTAT: rd_word = WORD_W'(msk_q);
         REG_SEND:  rd_word = WORD_W'(send_q);
         default: begin
            for (int k = 0; k < DATA_WORDS; k++)
               if (word_sel == DATA_BASE + 4'(k)) rd_word = dat_q[k];
         end
      endcase
   end
endmodule

// File: rtl/ipc_mbx_irq.sv
module ipc_mbx_irq
   import ipc_mbx_pkg::*;
#(
   parameter int NUM_BOX  = 4,
   parameter int NUM_CHAN = 8
) (
   input  logic [NUM_BOX-1:0][NUM_CHAN-1:0] src_all,
   input  logic [NUM_BOX-1:0][NUM_CHAN-1:0] dst_all,
   input  logic [NUM_BOX-1:0][NUM_CHAN-1:0] msk_all,
   input  logic [NUM_BOX-1:0][1:0]          send_all,
   output logic [NUM_CHAN-1:0][NUM_BOX-1:0] ris_w,
   output logic [NUM_CHAN-1:0][NUM_BOX-1:0] mis_w,
   output logic [NUM_CHAN-1:0]              irq_out
);
   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
      for (genvar b = 0; b < NUM_BOX; b++) begin : g_box
         assign ris_w[c][b] = ((send_all[b] == SEND_REQ) && dst_all[b][c])
                           || ((send_all[b] == SEND_ACK) && src_all[b][c]);
         assign mis_w[c][b] = ris_w[c][b] && msk_all[b][c];
      end
      assign irq_out[c] = |mis_w[c];
   end
endmodule

// File: rtl/ipc_mailbox_hub.sv
module ipc_mailbox_hub
   import ipc_mbx_pkg::*;
#(
   parameter int NUM_BOX    = 4,
   parameter int NUM_CHAN   = 8,
   parameter int DATA_WORDS = 7,
   parameter int MODE_W     = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_we,
   input  logic                bus_re,
   input  logic [11:0]         bus_addr,
   input  logic [31:0]         bus_wdata,
   output logic [31:0]         bus_rdata,
   output logic [NUM_CHAN-1:0] irq_out
);
   localparam int BOX_IDX_W = (NUM_BOX  > 1) ? $clog2(NUM_BOX)  : 1;
   localparam int CH_IDX_W  = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

   if (NUM_BOX < 1 || NUM_BOX > 32)        begin : g_bad_box  $error("NUM_BOX must be 1..32");   end
   if (NUM_CHAN < 1 || NUM_CHAN > 32)      begin : g_bad_chan $error("NUM_CHAN must be 1..32");  end
   if (DATA_WORDS < 1 || DATA_WORDS > 7)   begin : g_bad_data $error("DATA_WORDS must be 1..7"); end
   if (MODE_W < 0 || MODE_W > 32)          begin : g_bad_mode $error("MODE_W must be 0..32");    end

   logic [NUM_BOX-1:0][NUM_CHAN-1:0] src_all;
   logic [NUM_BOX-1:0][NUM_CHAN-1:0] dst_all;
   logic [NUM_BOX-1:0][NUM_CHAN-1:0] msk_all;
   logic [NUM_BOX-1:0][1:0]          send_all;
   logic [NUM_BOX-1:0][WORD_W-1:0]   slot_rd;
   logic [NUM_CHAN-1:0][NUM_BOX-1:0] ris_w;
   logic [NUM_CHAN-1:0][NUM_BOX-1:0] mis_w;

   logic                 in_irq;
   logic [4:0]           box_full;
   logic [7:0]           chan_full;
   logic                 box_hit;
   logic                 chan_hit;
   logic [BOX_IDX_W-1:0] box_sel;
   logic [CH_IDX_W-1:0]  chan_sel;
   logic [WORD_W-1:0]    rd_next;

   assign in_irq    = bus_addr[11];
   assign box_full  = bus_addr[10:6];
   assign chan_full = bus_addr[10:3];
   assign box_hit   = !in_irq && (32'(box_full) < NUM_BOX);
   assign chan_hit  = in_irq && (32'(chan_full) < NUM_CHAN);
   assign box_sel   = box_full[BOX_IDX_W-1:0];
   assign chan_sel  = chan_full[CH_IDX_W-1:0];

   for (genvar b = 0; b < NUM_BOX; b++) begin : g_slot
      ipc_mbx_slot #(
         .NUM_CHAN   (NUM_CHAN),
         .DATA_WORDS (DATA_WORDS),
         .MODE_W     (MODE_W)
      ) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (bus_we && box_hit && (box_sel == BOX_IDX_W'(b))),
         .word_sel (bus_addr[5:2]),
         .wdata    (bus_wdata),
         .rd_word  (slot_rd[b]),
         .src_q    (src_all[b]),
         .dst_q    (dst_all[b]),
         .msk_q    (msk_all[b]),
         .send_q   (send_all[b])
      );
   end

   ipc_mbx_irq #(
      .NUM_BOX  (NUM_BOX),
      .NUM_CHAN (NUM_CHAN)
   ) u_irq (
      .src_all  (src_all),
      .dst_all  (dst_all),
      .msk_all  (msk_all),
      .send_all (send_all),
      .ris_w    (ris_w),
      .mis_w    (mis_w),
      .irq_out  (irq_out)
   );

   always_comb begin
      rd_next = '0;
      if (box_hit)
         rd_next = slot_rd[box_sel];
      else if (chan_hit)
         rd_next = bus_addr[2] ? WORD_W'(ris_w[chan_sel]) : WORD_W'(mis_w[chan_sel]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      bus_rdata <= '0;
      else if (bus_re) bus_rdata <= rd_next;
   end
endmodule

// File: rtl/ipc_mbx_checker.sv
module ipc_mbx_checker #(
   parameter int NUM_BOX  = 4,
   parameter int NUM_CHAN = 8
) (
   input logic                             clk,
   input logic                             rst_n,
   input logic                             bus_we,
   input logic                             bus_re,
   input logic [11:0]                      bus_addr,
   input logic [31:0]                      bus_wdata,
   input logic [31:0]                      bus_rdata,
   input logic [NUM_CHAN-1:0]              irq_out,
   input logic [NUM_BOX-1:0][NUM_CHAN-1:0] src_all,
   input logic [NUM_BOX-1:0][NUM_CHAN-1:0] dst_all,
   input logic [NUM_BOX-1:0][NUM_CHAN-1:0] msk_all,
   input logic [NUM_BOX-1:0][1:0]          send_all
);
   logic [NUM_CHAN-1:0] mask_any;
   logic                send_any;

   always_comb begin
      mask_any = '0;
      send_any = 1'b0;
      for (int b = 0; b < NUM_BOX; b++) begin
         mask_any = mask_any | msk_all[b];
         send_any = send_any | (send_all[b] != 2'd0);
      end
   end

   // R1: the first active cycle still shows the reset state
   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (irq_out == '0 && bus_rdata == '0));

   // R11: read data moves only on a read strobe
   assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_re |=> $stable(bus_rdata));

   // R10: writes into the status region change no mailbox state
   assert_status_wr_inert_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr[11]) |=> ($stable(src_all) && $stable(dst_all)
                                    && $stable(msk_all) && $stable(send_all)));

   // R8: an interrupt line needs an enabled mask bit and an active send somewhere
   for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan_chk
      assert_irq_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
         irq_out[c] |-> (mask_any[c] && send_any));
   end

   for (genvar b = 0; b < NUM_BOX; b++) begin : g_box_chk
      logic src_wr;
      assign src_wr = bus_we && !bus_addr[11] && (32'(bus_addr[10:6]) == b)
                      && (bus_addr[5:2] == 4'd0);

      // R5: an owned mailbox keeps its owner on a nonzero claim
      assert_owner_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (src_wr && bus_wdata[NUM_CHAN-1:0] != '0 && src_all[b] != '0)
            |=> $stable(src_all[b]));

      // R6: release empties the mailbox control state
      assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (src_wr && bus_wdata[NUM_CHAN-1:0] == '0)
            |=> (src_all[b] == '0 && dst_all[b] == '0
                 && msk_all[b] == '0 && send_all[b] == 2'd0));
   end
endmodule

bind ipc_mailbox_hub ipc_mbx_checker #(
   .NUM_BOX  (NUM_BOX),
   .NUM_CHAN (NUM_CHAN)
) u_ipc_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_we    (bus_we),
   .bus_re    (bus_re),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_out   (irq_out),
   .src_all   (src_all),
   .dst_all   (dst_all),
   .msk_all   (msk_all),
   .send_all  (send_all)
);

// File: tb/ipc_mailbox_hub_bench.sv
`timescale 1ns/1ps
module ipc_mailbox_hub_bench;
   localparam int NCH = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_we = 1'b0;
   logic            bus_re = 1'b0;
   logic [11:0]     bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic [NCH-1:0]  irq_out;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   bit pend   = 1'b0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   ipc_mailbox_hub u_ipc_mailbox_hub (
      .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   // monitor: a read strobe seen at a rising edge is compared at the next falling edge
   always @(posedge clk) pend <= bus_re;

   always @(negedge clk) begin
      if (pend) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read result act=%h", bus_rdata);
         end else begin
            logic [31:0] e;
            string       t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               errors++;
               $display("FAIL %s act=%h exp=%h", t, bus_rdata, e);
            end
         end
      end
   end

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
      @(negedge clk);
      bus_re = 1'b1; bus_addr = a;
      exp_q.push_back(e);
      tag_q.push_back(t);
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic chk_irq(input logic [NCH-1:0] e, input string t);
      checks++;
      if (irq_out !== e) begin
         errors++;
         $display("FAIL %s irq act=%h exp=%h", t, irq_out, e);
      end
   endtask

   function automatic logic [11:0] ba(input int b, input int off);
      return 12'(b * 64 + off);
   endfunction

   initial begin
      fork
         begin
            repeat (100000) @(posedge clk);
            if (!done) begin
               checks++; errors++;
               $display("FAIL watchdog act=running exp=finished");
               $display("CHECKS %0d ERRORS %0d", checks, errors);
               $finish;
            end
         end
      join_none

      repeat (3) @(negedge clk);
      // R1: reset state
      chk_irq('0, "R1 reset");
      checks++;
      if (bus_rdata !== 32'h0) begin errors++; $display("FAIL R1 rdata act=%h exp=0", bus_rdata); end
      rst_n = 1'b1;
      chk_irq('0, "R1 after release");
      rd(ba(0, 12'h00), 0, "R1 src");
      rd(ba(1, 12'h0C), 0, "R1 dstat");
      rd(ba(3, 12'h1C), 0, "R1 mstat");
      rd(ba(2, 12'h24), 0, "R1 data0");
      rd(12'h804, 0, "R1 raw ch0");

      // R2: data words
      for (int k = 0; k < 7; k++) wr(ba(1, 12'h24 + 4 * k), 32'hA500_0000 + 32'(k * 17));
      for (int k = 0; k < 7; k++) rd(ba(1, 12'h24 + 4 * k), 32'hA500_0000 + 32'(k * 17), "R2 data word");

      // R3: destination set/clear
      wr(ba(1, 12'h04), 32'h05); rd(ba(1, 12'h0C), 32'h05, "R3 dset");
      wr(ba(1, 12'h08), 32'h04); rd(ba(1, 12'h0C), 32'h01, "R3 dclr");
      wr(ba(1, 12'h04), 32'h80); rd(ba(1, 12'h0C), 32'h81, "R3 dset or");

      // R4: mask set/clear
      wr(ba(1, 12'h14), 32'h03); rd(ba(1, 12'h1C), 32'h03, "R4 mset");
      wr(ba(1, 12'h18), 32'h02); rd(ba(1, 12'h1C), 32'h01, "R4 mclr");

      // R12: mode keeps low two bits, no interrupt effect
      wr(ba(1, 12'h10), 32'hFFFF);
      chk_irq('0, "R12 mode no irq");
      rd(ba(1, 12'h10), 32'h3, "R12 mode");

      // cross setup: box2 ch1->ch0, box3 ch0->ch1
      wr(ba(2, 12'h00), 32'h02); wr(ba(2, 12'h04), 32'h01); wr(ba(2, 12'h14), 32'h03);
      wr(ba(3, 12'h00), 32'h01); wr(ba(3, 12'h04), 32'h02); wr(ba(3, 12'h14), 32'h03);

      // R5: claim of an owned mailbox ignored
      wr(ba(2, 12'h00), 32'h04);
      rd(ba(2, 12'h00), 32'h02, "R5 owner kept");

      // R11: rdata holds across idle cycles
      repeat (3) @(negedge clk);
      checks++;
      if (bus_rdata !== 32'h02) begin errors++; $display("FAIL R11 hold act=%h exp=2", bus_rdata); end

      // R7 / R9: send request and acknowledge
      wr(ba(2, 12'h20), 32'h1);
      chk_irq(8'h01, "R7 req irq same cycle R11");
      rd(12'h804, 32'h04, "R9 raw ch0");
      rd(12'h800, 32'h04, "R9 masked ch0");
      rd(12'h80C, 32'h00, "R7 raw ch1 idle");
      wr(ba(2, 12'h20), 32'h2);
      chk_irq(8'h02, "R7 ack irq");
      rd(ba(2, 12'h20), 32'h2, "R7 send readback");
      rd(12'h80C, 32'h04, "R7 raw ch1 ack");
      rd(12'h804, 32'h00, "R7 raw ch0 after ack");
      wr(ba(3, 12'h20), 32'h1);
      chk_irq(8'h02, "R8 two boxes");
      rd(12'h80C, 32'h0C, "R9 raw ch1 two bits");
      wr(ba(2, 12'h20), 32'h0);
      rd(12'h80C, 32'h08, "R7 idle clears");
      wr(ba(3, 12'h20), 32'h0);
      chk_irq(8'h00, "R7 all idle");

      // R8: masking
      wr(ba(3, 12'h18), 32'h02);
      wr(ba(3, 12'h20), 32'h1);
      chk_irq(8'h00, "R8 masked off");
      rd(12'h80C, 32'h08, "R8 raw unmasked");
      rd(12'h808, 32'h00, "R8 masked zero");
      wr(ba(3, 12'h14), 32'h02);
      chk_irq(8'h02, "R8 mask on");
      rd(12'h808, 32'h08, "R8 masked set");
      wr(ba(3, 12'h20), 32'h0);

      // R9: highest channel
      wr(ba(3, 12'h04), 32'h80);
      wr(ba(3, 12'h14), 32'h80);
      wr(ba(3, 12'h20), 32'h1);
      chk_irq(8'h82, "R9 ch7 irq");
      rd(12'h83C, 32'h08, "R9 raw ch7");
      rd(12'h838, 32'h08, "R9 masked ch7");
      wr(ba(3, 12'h20), 32'h0);

      // R6: release
      wr(ba(3, 12'h24), 32'h1234);
      wr(ba(3, 12'h20), 32'h1);
      wr(ba(3, 12'h00), 32'h0);
      chk_irq(8'h00, "R6 release irq");
      rd(ba(3, 12'h00), 0, "R6 src");
      rd(ba(3, 12'h0C), 0, "R6 dst");
      rd(ba(3, 12'h1C), 0, "R6 mask");
      rd(ba(3, 12'h20), 0, "R6 send");
      rd(ba(3, 12'h24), 32'h1234, "R6 data kept");
      wr(ba(3, 12'h00), 32'h10);
      rd(ba(3, 12'h00), 32'h10, "R6 reclaim");

      // R10: unmapped
      wr(12'h100, 32'hFFFF_FFFF);
      wr(12'h104, 32'hFF);
      rd(12'h100, 0, "R10 box4 read");
      rd(ba(0, 12'h00), 0, "R10 box0 src untouched");
      rd(ba(0, 12'h0C), 0, "R10 box0 dst untouched");
      rd(12'h840, 0, "R10 ch8 read");
      wr(ba(2, 12'h04), 32'h01); wr(ba(2, 12'h20), 32'h1);
      wr(12'h804, 32'h0);
      rd(12'h804, 32'h04, "R10 status write inert");
      wr(ba(2, 12'h20), 32'h0);

      repeat (2) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin errors++; $display("FAIL R11 pending act=%0d exp=0", exp_q.size()); end
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule